// File: doc/BRIEF.md
# Accelerator Operation-State Controller

This block is the command and state sequencer at the top of a secure accelerator. A host writes command codes into a command port, and the controller moves through busy, idle and locked states. It publishes the current state as an 8-bit status code, asks external engines to run a program or to wipe storage through request/acknowledge handshakes, and pulses a done interrupt whenever a busy phase ends. It also gates host accesses to the accelerator memories. Incoming error events are sorted into recoverable and fatal classes, which drive a one-shot recoverable alert and a sticky fatal alert.

The states are `CS_WIPE_INT` (internal wipe after reset), `CS_IDLE`, `CS_RUN` (program executing), `CS_RUN_WIPE` (internal wipe closing a run), `CS_WIPE_D` and `CS_WIPE_I` (memory wipes) and `CS_LOCKED`. The transitions are:
- reset → `CS_WIPE_INT`;
- `CS_WIPE_INT` → `CS_IDLE` on the wipe acknowledge;
- `CS_IDLE` → `CS_RUN`, `CS_WIPE_D` or `CS_WIPE_I` on a valid command;
- `CS_RUN` → `CS_RUN_WIPE` on program end or on a recoverable error;
- `CS_RUN_WIPE` → `CS_IDLE` on the wipe acknowledge;
- `CS_WIPE_D` / `CS_WIPE_I` → `CS_IDLE` on their acknowledge;
- any state → `CS_LOCKED` on a fatal error.

`CS_LOCKED` is left only through reset.

Top module: `accel_state_ctrl`

## Requirements
- R1: After reset the status is 0x04 (internal wipe busy), `wipe_int_req_o` is high and `idle_o` is low. The first `wipe_int_ack_i` moves the status to 0x00 (idle).
- R2: In idle, a command write with code 0xA5 gives status 0x01 (running), code 0x3C gives 0x02 (data-memory wipe) and code 0x96 gives 0x03 (instruction-memory wipe). Any other code leaves the status at 0x00. Command writes in any non-idle state are ignored.
- R3: While running, `exec_req_o` is high. `exec_done_i` drops it and starts an internal wipe (`wipe_int_req_o` high, status still 0x01) that returns to idle on its acknowledge. A memory wipe holds its request until the matching acknowledge, then returns to idle.
- R4: `done_irq_o` pulses for exactly one cycle, in the cycle the status first shows idle or locked after any busy status. It stays low for a move out of idle.
- R5: `idle_o` is high exactly when the status is 0x00.
- R6: A host memory request is forwarded (`mem_en_o`, with `mem_we_o` following the write flag) only in idle. Outside idle, `host_rdata_o` is zero and nothing reaches the memory.
- R7: A host memory request in any busy state is a fatal error recorded in fatal-cause bit 9. While locked, a request is blocked without any new error.
- R8: A fatal error gives status 0xFF (locked) and drops `exec_req_o`. It raises both memory wipe requests, each held until its own acknowledge, and sets `alert_fatal_o`, which stays high until reset. Commands are ignored while locked.
- R9: During a run, a software error (`sw_err_i`, error bits 3:0, when `sw_fatal_en_i` is 0) or an entropy error (`rec_err_i`, bits 5:4) loads those bits into `err_bits_o`, pulses `alert_rec_o` for one cycle and ends the run through the internal wipe. It takes precedence over `exec_done_i` in the same cycle. Outside a run both inputs are ignored.
- R10: With `sw_fatal_en_i` at 1, a software error during a run is fatal and sets bit 11 in both `fatal_cause_o` and `err_bits_o`.
- R11: Every fatal error ORs its bits into `fatal_cause_o`: external faults in bits 8:6, illegal bus access in bit 9, wipe failure in bit 10, escalated software error in bit 11. `err_bits_o` takes the fatal bits only when the error hits during `CS_RUN`.
- R12: Accepting the run command clears `err_bits_o`. `errbits_clr_i` clears it in any state except while the status is 0x01, where the clear is ignored.
- R13: `wipe_int_fail_i` during an internal wipe (after reset or after a run) locks the controller with fatal-cause bit 10.
- R14: When a fatal and a recoverable error arrive in the same cycle, the fatal one wins and `alert_rec_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | 8 | Command code |
| sw_fatal_en_i | input | 1 | Treat software errors as fatal |
| errbits_clr_i | input | 1 | Host write to the error-bits register |
| status_o | output | 8 | Status code |
| idle_o | output | 1 | High when idle |
| done_irq_o | output | 1 | One-cycle done interrupt |
| err_bits_o | output | 12 | Error bits of the last run |
| fatal_cause_o | output | 12 | Accumulated fatal causes |
| host_mem_req_i | input | 1 | Host memory access request |
| host_mem_we_i | input | 1 | Host access is a write |
| host_rdata_o | output | DATA_W | Read data returned to the host |
| mem_en_o | output | 1 | Access forwarded to memory |
| mem_we_o | output | 1 | Forwarded write enable |
| mem_rdata_i | input | DATA_W | Read data from memory |
| exec_req_o | output | 1 | Run request to the execution engine |
| exec_done_i | input | 1 | Program finished |
| wipe_int_req_o | output | 1 | Internal-state wipe request |
| wipe_int_ack_i | input | 1 | Internal-state wipe finished |
| wipe_int_fail_i | input | 1 | Internal-state wipe failed |
| wipe_dmem_req_o | output | 1 | Data-memory wipe request |
| wipe_dmem_ack_i | input | 1 | Data-memory wipe finished |
| wipe_imem_req_o | output | 1 | Instruction-memory wipe request |
| wipe_imem_ack_i | input | 1 | Instruction-memory wipe finished |
| sw_err_i | input | 4 | Software error events |
| rec_err_i | input | 2 | Entropy error events |
| fatal_err_i | input | 3 | External fatal fault events |
| alert_rec_o | output | 1 | Recoverable alert pulse |
| alert_fatal_o | output | 1 | Sticky fatal alert |

## Verification
Two pairs of functions can collide in one cycle. The first is program completion against a recoverable error: the bench raises `exec_done_i` together with the error patterns. The error must still load `err_bits_o` and pulse the alert, and the run must end only once. The second is a recoverable error against a fatal one: the bench drives an entropy error and an external fault in the same cycle. It then checks that the status goes to 0xFF, that `err_bits_o` carries only the fatal bit, and that `alert_rec_o` never rises.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;
    localparam int unsigned CMD_W    = 8;
    localparam int unsigned STAT_W   = 8;
    localparam int unsigned N_SW     = 4;
    localparam int unsigned N_REC    = 2;
    localparam int unsigned N_FEXT   = 3;
    localparam int unsigned SW_LSB   = 0;
    localparam int unsigned REC_LSB  = SW_LSB + N_SW;
    localparam int unsigned FEXT_LSB = REC_LSB + N_REC;
    localparam int unsigned BIT_BUS  = FEXT_LSB + N_FEXT;
    localparam int unsigned BIT_WIPE = BIT_BUS + 1;
    localparam int unsigned BIT_FSW  = BIT_WIPE + 1;
    localparam int unsigned ERR_W    = BIT_FSW + 1;

    localparam logic [CMD_W-1:0] CMD_RUN    = 8'hA5;
    localparam logic [CMD_W-1:0] CMD_WIPE_D = 8'h3C;
    localparam logic [CMD_W-1:0] CMD_WIPE_I = 8'h96;

    localparam logic [STAT_W-1:0] ST_IDLE      = 8'h00;
    localparam logic [STAT_W-1:0] ST_BUSY_RUN  = 8'h01;
    localparam logic [STAT_W-1:0] ST_BUSY_WD   = 8'h02;
    localparam logic [STAT_W-1:0] ST_BUSY_WI   = 8'h03;
    localparam logic [STAT_W-1:0] ST_BUSY_WINT = 8'h04;
    localparam logic [STAT_W-1:0] ST_LOCKED    = 8'hFF;

    typedef enum logic [2:0] {
        CS_WIPE_INT,
        CS_IDLE,
        CS_RUN,
        CS_RUN_WIPE,
        CS_WIPE_D,
        CS_WIPE_I,
        CS_LOCKED
    } ctrl_state_e;
endpackage

// File: rtl/accel_err_classify.sv
module accel_err_classify
    import accel_ctrl_pkg::*;
(
    input  logic              in_run_i,
    input  logic              in_int_wipe_i,
    input  logic              sw_fatal_en_i,
    input  logic [N_SW-1:0]   sw_err_i,
    input  logic [N_REC-1:0]  rec_err_i,
    input  logic [N_FEXT-1:0] fatal_ext_i,
    input  logic              bus_illegal_i,
    input  logic              wipe_fail_i,
    output logic              fatal_hit_o,
    output logic              rec_hit_o,
    output logic [ERR_W-1:0]  fatal_code_o,
    output logic [ERR_W-1:0]  rec_code_o
);
    logic sw_seen;

    always_comb begin
        sw_seen      = in_run_i && (|sw_err_i);
        fatal_code_o = '0;
        fatal_code_o[FEXT_LSB +: N_FEXT] = fatal_ext_i;
        fatal_code_o[BIT_BUS]  = bus_illegal_i;
        fatal_code_o[BIT_WIPE] = in_int_wipe_i && wipe_fail_i;
        fatal_code_o[BIT_FSW]  = sw_seen && sw_fatal_en_i;
        rec_code_o = '0;
        if (in_run_i) begin
            if (!sw_fatal_en_i) begin
                rec_code_o[SW_LSB +: N_SW] = sw_err_i;
            end
            rec_code_o[REC_LSB +: N_REC] = rec_err_i;
        end
        fatal_hit_o = |fatal_code_o;
        rec_hit_o   = (|rec_code_o) && !fatal_hit_o;
    end
endmodule

// File: rtl/accel_bus_gate.sv
module accel_bus_gate #(
    parameter int unsigned DW = 32
) (
    input  logic          host_req_i,
    input  logic          host_we_i,
    input  logic          open_i,
    input  logic          locked_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          mem_en_o,
    output logic          mem_we_o,
    output logic [DW-1:0] host_rdata_o,
    output logic          illegal_o
);
    assign mem_en_o     = host_req_i && open_i;
    assign mem_we_o     = host_req_i && open_i && host_we_i;
    assign host_rdata_o = open_i ? mem_rdata_i : '0;
    assign illegal_o    = host_req_i && !open_i && !locked_i;
endmodule

// File: rtl/accel_state_ctrl.sv
module accel_state_ctrl
    import accel_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_we_i,
    input  logic [CMD_W-1:0]  cmd_wdata_i,
    input  logic              sw_fatal_en_i,
    input  logic              errbits_clr_i,
    output logic [STAT_W-1:0] status_o,
    output logic              idle_o,
    output logic              done_irq_o,
    output logic [ERR_W-1:0]  err_bits_o,
    output logic [ERR_W-1:0]  fatal_cause_o,
    input  logic              host_mem_req_i,
    input  logic              host_mem_we_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              mem_en_o,
    output logic              mem_we_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              exec_req_o,
    input  logic              exec_done_i,
    output logic              wipe_int_req_o,
    input  logic              wipe_int_ack_i,
    input  logic              wipe_int_fail_i,
    output logic              wipe_dmem_req_o,
    input  logic              wipe_dmem_ack_i,
    output logic              wipe_imem_req_o,
    input  logic              wipe_imem_ack_i,
    input  logic [N_SW-1:0]   sw_err_i,
    input  logic [N_REC-1:0]  rec_err_i,
    input  logic [N_FEXT-1:0] fatal_err_i,
    output logic              alert_rec_o,
    output logic              alert_fatal_o
);
    ctrl_state_e state_q, state_d;
    logic fatal_hit, rec_hit, bus_illegal;
    logic [ERR_W-1:0] fatal_code, rec_code;
    logic busy_q, end_busy, run_cmd;
    logic done_q, arec_q, afatal_q, lk_d_q, lk_i_q;
    logic [ERR_W-1:0] err_q, cause_q;

    accel_bus_gate #(.DW(DATA_W)) i_gate (
        .host_req_i   (host_mem_req_i),
        .host_we_i    (host_mem_we_i),
        .open_i       (state_q == CS_IDLE),
        .locked_i     (state_q == CS_LOCKED),
        .mem_rdata_i  (mem_rdata_i),
        .mem_en_o     (mem_en_o),
        .mem_we_o     (mem_we_o),
        .host_rdata_o (host_rdata_o),
        .illegal_o    (bus_illegal)
    );

    accel_err_classify i_class (
        .in_run_i      (state_q == CS_RUN),
        .in_int_wipe_i ((state_q == CS_WIPE_INT) || (state_q == CS_RUN_WIPE)),
        .sw_fatal_en_i (sw_fatal_en_i),
        .sw_err_i      (sw_err_i),
        .rec_err_i     (rec_err_i),
        .fatal_ext_i   (fatal_err_i),
        .bus_illegal_i (bus_illegal),
        .wipe_fail_i   (wipe_int_fail_i),
        .fatal_hit_o   (fatal_hit),
        .rec_hit_o     (rec_hit),
        .fatal_code_o  (fatal_code),
        .rec_code_o    (rec_code)
    );

    // Next-state logic; a fatal event overrides every other transition.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_WIPE_INT: if (wipe_int_ack_i) state_d = CS_IDLE;
            CS_IDLE: begin
                if (cmd_we_i) begin
                    case (cmd_wdata_i)
                        CMD_RUN:    state_d = CS_RUN;
                        CMD_WIPE_D: state_d = CS_WIPE_D;
                        CMD_WIPE_I: state_d = CS_WIPE_I;
                        default:    state_d = CS_IDLE;
                    endcase
                end
            end
            CS_RUN:      if (rec_hit || exec_done_i) state_d = CS_RUN_WIPE;
            CS_RUN_WIPE: if (wipe_int_ack_i) state_d = CS_IDLE;
            CS_WIPE_D:   if (wipe_dmem_ack_i) state_d = CS_IDLE;
            CS_WIPE_I:   if (wipe_imem_ack_i) state_d = CS_IDLE;
            CS_LOCKED:   state_d = CS_LOCKED;
            default:     state_d = CS_LOCKED;
        endcase
        if (fatal_hit) state_d = CS_LOCKED;
    end

    assign busy_q   = (state_q != CS_IDLE) && (state_q != CS_LOCKED);
    assign end_busy = busy_q && ((state_d == CS_IDLE) || (state_d == CS_LOCKED));
    assign run_cmd  = (state_q == CS_IDLE) && cmd_we_i && (cmd_wdata_i == CMD_RUN);

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CS_WIPE_INT;
        else         state_q <= state_d;
    end

    // Registered outputs: interrupt, alerts, error records, lock-time wipes.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            done_q   <= 1'b0;
            arec_q   <= 1'b0;
            afatal_q <= 1'b0;
            lk_d_q   <= 1'b0;
            lk_i_q   <= 1'b0;
            err_q    <= '0;
            cause_q  <= '0;
        end else begin
            done_q   <= end_busy;
            arec_q   <= rec_hit;
            afatal_q <= afatal_q || fatal_hit;
            cause_q  <= cause_q | fatal_code;
            if (fatal_hit && state_q != CS_LOCKED) begin
                lk_d_q <= 1'b1;
                lk_i_q <= 1'b1;
            end else begin
                if (wipe_dmem_ack_i) lk_d_q <= 1'b0;
                if (wipe_imem_ack_i) lk_i_q <= 1'b0;
            end
            if (fatal_hit && state_q == CS_RUN)            err_q <= fatal_code;
            else if (rec_hit)                              err_q <= rec_code;
            else if (run_cmd)                              err_q <= '0;
            else if (errbits_clr_i && state_q != CS_RUN &&
                     state_q != CS_RUN_WIPE)               err_q <= '0;
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            CS_WIPE_INT: status_o = ST_BUSY_WINT;
            CS_IDLE:     status_o = ST_IDLE;
            CS_RUN:      status_o = ST_BUSY_RUN;
            CS_RUN_WIPE: status_o = ST_BUSY_RUN;
            CS_WIPE_D:   status_o = ST_BUSY_WD;
            CS_WIPE_I:   status_o = ST_BUSY_WI;
            default:     status_o = ST_LOCKED;
        endcase
        idle_o          = (state_q == CS_IDLE);
        exec_req_o      = (state_q == CS_RUN);
        wipe_int_req_o  = (state_q == CS_WIPE_INT) || (state_q == CS_RUN_WIPE);
        wipe_dmem_req_o = (state_q == CS_WIPE_D) || lk_d_q;
        wipe_imem_req_o = (state_q == CS_WIPE_I) || lk_i_q;
        done_irq_o      = done_q;
        alert_rec_o     = arec_q;
        alert_fatal_o   = afatal_q;
        err_bits_o      = err_q;
        fatal_cause_o   = cause_q;
    end
endmodule

// File: rtl/accel_state_ctrl_chk.sv
module accel_state_ctrl_chk
    import accel_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [STAT_W-1:0] status_o,
    input logic              idle_o,
    input logic              done_irq_o,
    input logic              alert_rec_o,
    input logic              alert_fatal_o,
    input logic              mem_en_o,
    input logic [DATA_W-1:0] host_rdata_o,
    input logic [ERR_W-1:0]  err_bits_o,
    input logic [ERR_W-1:0]  fatal_cause_o,
    input logic              errbits_clr_i,
    input logic              cmd_we_i,
    input logic              exec_req_o
);
    assert_locked_terminal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o == ST_LOCKED |=> status_o == ST_LOCKED);
    assert_fatal_alert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alert_fatal_o |=> alert_fatal_o);
    assert_rec_alert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alert_rec_o |=> !alert_rec_o);
    assert_done_after_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_irq_o |-> ($past(status_o) != ST_IDLE && $past(status_o) != ST_LOCKED));
    assert_gate_idle_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_en_o |-> idle_o);
    assert_rdata_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !idle_o |-> host_rdata_o == '0);
    assert_idle_matches_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle_o |-> status_o == ST_IDLE);
    assert_errbits_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(status_o) != ST_BUSY_RUN && !$past(errbits_clr_i) && !$past(cmd_we_i))
        |-> $stable(err_bits_o));
    assert_cause_accumulates_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fatal_cause_o & $past(fatal_cause_o)) == $past(fatal_cause_o));
    assert_exec_in_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exec_req_o |-> status_o == ST_BUSY_RUN);
endmodule

bind accel_state_ctrl accel_state_ctrl_chk #(.DATA_W(DATA_W)) i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .status_o      (status_o),
    .idle_o        (idle_o),
    .done_irq_o    (done_irq_o),
    .alert_rec_o   (alert_rec_o),
    .alert_fatal_o (alert_fatal_o),
    .mem_en_o      (mem_en_o),
    .host_rdata_o  (host_rdata_o),
    .err_bits_o    (err_bits_o),
    .fatal_cause_o (fatal_cause_o),
    .errbits_clr_i (errbits_clr_i),
    .cmd_we_i      (cmd_we_i),
    .exec_req_o    (exec_req_o)
);

// File: tb/test_accel_state_ctrl.sv
module test_accel_state_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_we = 1'b0;
    logic [7:0] cmd_wdata = '0;
    logic sw_fatal_en = 1'b0, errbits_clr = 1'b0;
    logic [7:0] status;
    logic idle, done_irq;
    logic [11:0] err_bits, fatal_cause;
    logic host_req = 1'b0, host_we = 1'b0;
    logic [DW-1:0] host_rdata, mem_rdata = '0;
    logic mem_en, mem_we;
    logic exec_req, exec_done = 1'b0;
    logic wint_req, wint_ack = 1'b0, wint_fail = 1'b0;
    logic wd_req, wd_ack = 1'b0, wi_req, wi_ack = 1'b0;
    logic [3:0] sw_err = '0;
    logic [1:0] rec_err = '0;
    logic [2:0] fatal_err = '0;
    logic alert_rec, alert_fatal;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    accel_state_ctrl #(.DATA_W(DW)) i_accel_state_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
        .sw_fatal_en_i(sw_fatal_en), .errbits_clr_i(errbits_clr),
        .status_o(status), .idle_o(idle), .done_irq_o(done_irq),
        .err_bits_o(err_bits), .fatal_cause_o(fatal_cause),
        .host_mem_req_i(host_req), .host_mem_we_i(host_we), .host_rdata_o(host_rdata),
        .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_rdata_i(mem_rdata),
        .exec_req_o(exec_req), .exec_done_i(exec_done),
        .wipe_int_req_o(wint_req), .wipe_int_ack_i(wint_ack), .wipe_int_fail_i(wint_fail),
        .wipe_dmem_req_o(wd_req), .wipe_dmem_ack_i(wd_ack),
        .wipe_imem_req_o(wi_req), .wipe_imem_ack_i(wi_ack),
        .sw_err_i(sw_err), .rec_err_i(rec_err), .fatal_err_i(fatal_err),
        .alert_rec_o(alert_rec), .alert_fatal_o(alert_fatal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {cmd_we, errbits_clr, host_req, host_we, exec_done, wint_ack, wint_fail} = '0;
        {wd_ack, wi_ack, sw_fatal_en} = '0;
        sw_err = '0; rec_err = '0; fatal_err = '0; cmd_wdata = '0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic to_idle();
        wint_ack = 1'b1; step(); wint_ack = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        cmd_we = 1'b1; cmd_wdata = c; step(); cmd_we = 1'b0;
    endtask

    function automatic logic [7:0] exp_status(input logic [7:0] c);
        case (c)
            8'hA5:   return 8'h01;
            8'h3C:   return 8'h02;
            8'h96:   return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state (R1, R5)
        do_reset();
        chk("R1 status after reset", status, 8'h04);
        chk("R1 wipe request after reset", wint_req, 1);
        chk("R5 idle low in reset wipe", idle, 0);
        to_idle();
        chk("R1 idle after wipe ack", status, 8'h00);
        chk("R4 done on reset wipe end", done_irq, 1);
        chk("R5 idle high", idle, 1);
        step();
        chk("R4 done single cycle", done_irq, 0);

        // Command sweep over every code (R2, R3, R4)
        for (int c = 0; c < 256; c++) begin
            logic [7:0] es;
            es = exp_status(8'(c));
            send_cmd(8'(c));
            chk("R2 status after command", status, es);
            chk("R4 no done on leaving idle", done_irq, 0);
            if (es != 8'h00) begin
                send_cmd(8'hA5);
                chk("R2 command ignored while busy", status, es);
                if (es == 8'h01) begin
                    chk("R3 run request", exec_req, 1);
                    exec_done = 1'b1; step(); exec_done = 1'b0;
                    chk("R3 run ends in wipe", {status, 7'd0, wint_req, 7'd0, exec_req}, {8'h01, 7'd0, 1'b1, 8'h00});
                    wint_ack = 1'b1; step(); wint_ack = 1'b0;
                end else if (es == 8'h02) begin
                    chk("R3 dmem wipe request", {wd_req, wi_req}, 2'b10);
                    wd_ack = 1'b1; step(); wd_ack = 1'b0;
                end else begin
                    chk("R3 imem wipe request", {wd_req, wi_req}, 2'b01);
                    wi_ack = 1'b1; step(); wi_ack = 1'b0;
                end
                chk("R3 back to idle", status, 8'h00);
                chk("R4 done on busy exit", done_irq, 1);
                step();
            end
        end

        // Errors outside a run are ignored (R9)
        sw_err = 4'hF; rec_err = 2'h3; step(); sw_err = '0; rec_err = '0;
        chk("R9 idle ignores errors status", status, 8'h00);
        chk("R9 idle ignores errors bits", err_bits, 0);
        chk("R9 idle no rec alert", alert_rec, 0);

        // Recoverable pattern sweep, some coinciding with exec_done (R9)
        for (int p = 1; p < 64; p++) begin
            send_cmd(8'hA5);
            chk("R12 run start clears bits", err_bits, 0);
            sw_err = 4'(p); rec_err = 2'(p >> 4); exec_done = p[0];
            step();
            sw_err = '0; rec_err = '0; exec_done = 1'b0;
            chk("R9 err bits loaded", err_bits, 32'(p));
            chk("R9 rec alert pulse", alert_rec, 1);
            chk("R9 internal wipe after error", {status, 7'd0, wint_req}, {8'h01, 8'h01});
            step();
            chk("R9 rec alert one cycle", alert_rec, 0);
            wint_ack = 1'b1; step(); wint_ack = 1'b0;
            chk("R9 idle after recovery", status, 8'h00);
            chk("R9 no fatal alert", alert_fatal, 0);
        end

        // Error-bit clearing (R12)
        send_cmd(8'hA5);
        rec_err = 2'b01; step(); rec_err = '0;
        errbits_clr = 1'b1; step(); errbits_clr = 1'b0;
        chk("R12 clear ignored while running", err_bits, 12'h010);
        wint_ack = 1'b1; step(); wint_ack = 1'b0;
        errbits_clr = 1'b1; step(); errbits_clr = 1'b0;
        chk("R12 clear in idle", err_bits, 0);

        // Bus gate (R6, R7, R8, R11)
        host_req = 1'b1; host_we = 1'b1; mem_rdata = 32'hCAFE_1234; #1;
        chk("R6 forward in idle", {mem_en, mem_we}, 2'b11);
        chk("R6 read data in idle", host_rdata, 32'hCAFE_1234);
        host_req = 1'b0; host_we = 1'b0;
        send_cmd(8'h3C);
        #1;
        chk("R6 read data blanked when busy", host_rdata, 0);
        host_req = 1'b1; #1;
        chk("R6 no forward when busy", mem_en, 0);
        step(); host_req = 1'b0;
        chk("R7 illegal access locks", status, 8'hFF);
        chk("R7 cause bit 9", fatal_cause, 12'h200);
        chk("R11 err bits untouched outside run", err_bits, 0);
        chk("R8 fatal alert", alert_fatal, 1);
        chk("R4 done on lock from busy", done_irq, 1);
        chk("R8 both wipes requested", {wd_req, wi_req}, 2'b11);
        wd_ack = 1'b1; step(); wd_ack = 1'b0;
        chk("R8 dmem wipe released", {wd_req, wi_req}, 2'b01);
        wi_ack = 1'b1; step(); wi_ack = 1'b0;
        chk("R8 imem wipe released", {wd_req, wi_req}, 2'b00);
        send_cmd(8'hA5);
        chk("R8 command ignored when locked", status, 8'hFF);
        host_req = 1'b1; #1;
        chk("R7 blocked when locked", {mem_en, 31'd0} | host_rdata, 0);
        step(); host_req = 1'b0;
        chk("R7 no new cause when locked", fatal_cause, 12'h200);
        repeat (5) step();
        chk("R8 fatal alert sticks", alert_fatal, 1);

        // Escalated software error (R10)
        do_reset(); to_idle();
        sw_fatal_en = 1'b1;
        send_cmd(8'hA5);
        sw_err = 4'h2; step(); sw_err = '0;
        chk("R10 escalated to lock", status, 8'hFF);
        chk("R10 cause bit 11", fatal_cause, 12'h800);
        chk("R10 err bits bit 11", err_bits, 12'h800);
        chk("R10 no rec alert", alert_rec, 0);
        chk("R8 run request dropped", exec_req, 0);

        // Fatal and recoverable in the same cycle (R14, R11)
        do_reset(); to_idle();
        send_cmd(8'hA5);
        rec_err = 2'b10; fatal_err = 3'b001; step(); rec_err = '0; fatal_err = '0;
        chk("R14 fatal wins status", status, 8'hFF);
        chk("R14 rec alert suppressed", alert_rec, 0);
        chk("R11 fatal in run sets err bits", err_bits, 12'h040);
        step();
        chk("R14 rec alert stays low", alert_rec, 0);

        // External fatal sweep in idle (R11)
        for (int f = 1; f < 8; f++) begin
            do_reset(); to_idle(); step();
            fatal_err = 3'(f); step(); fatal_err = '0;
            chk("R11 cause from external fault", fatal_cause, 32'(f) << 6);
            chk("R11 err bits unchanged in idle", err_bits, 0);
            chk("R4 no done from idle lock", done_irq, 0);
            chk("R8 status locked", status, 8'hFF);
        end

        // Wipe failures (R13)
        do_reset();
        wint_fail = 1'b1; step(); wint_fail = 1'b0;
        chk("R13 reset wipe failure locks", status, 8'hFF);
        chk("R13 cause bit 10", fatal_cause, 12'h400);
        do_reset(); to_idle();
        send_cmd(8'hA5);
        exec_done = 1'b1; step(); exec_done = 1'b0;
        wint_fail = 1'b1; step(); wint_fail = 1'b0;
        chk("R13 run wipe failure locks", status, 8'hFF);
        chk("R13 cause bit 10 after run", fatal_cause, 12'h400);
        chk("R11 err bits kept after run wipe", err_bits, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule